// File: doc/BRIEF.md
# Instruction Address Register with Return Stack

This block holds the address of the next instruction for a small processor front end. In a normal cycle it steps forward by one instruction width (4 bytes). On a branch strobe it takes a supplied target address in place of that step. On a call strobe it stores the address of the instruction that follows the call in an on-chip last-in first-out stack and jumps to the target in the same cycle. On a return strobe it takes the newest stored address back into the counter.

Fetch logic upstream decides what happens each cycle and drives one or more strobes. When several strobes are high at once, a fixed priority settles them. The stack has a fixed depth. A call made while the stack is full, or a return made while it is empty, is refused. The refusal shows as a single-cycle error pulse, and neither the counter nor the stack changes.

Top module: `pc_callstack`

## Requirements
- R1: A synchronous reset, sampled at a rising edge, sets the address to RESET_VEC (default 0), empties the stack (empty=1, full=0) and clears the error output. Reset wins over every other strobe.
- R2: When adv_en is high and no strobe is active, the address grows by 4 at the next edge and wraps modulo 2^ADDR_W (0xFFFFFFFC steps to 0).
- R3: When adv_en and all strobes are low, the address keeps its value.
- R4: A branch strobe loads tgt_addr into the address at the next edge, whatever the value of adv_en.
- R5: A call strobe, with the stack not full, pushes the current address plus 4 and loads tgt_addr into the address in the same edge. After the push, empty reads 0.
- R6: A return strobe, with the stack not empty, loads the newest stored address into the address and removes that entry. Entries come back in reverse order of their calls.
- R7: Priority from highest to lowest is reset, return, call, branch, then the step of 4.
- R8: full is 1 exactly when DEPTH (default 8) entries are stored. A call while full raises stk_err for one cycle and leaves both the address and the stack as they were.
- R9: A return while empty raises stk_err for one cycle, leaves the address as it was, and the stack stays empty.
- R10: stk_err is high only in the cycle right after a refused call or return, and low after every accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Step forward by one instruction |
| br_req | input | 1 | Load tgt_addr |
| call_req | input | 1 | Save next address, load tgt_addr |
| ret_req | input | 1 | Restore the newest saved address |
| tgt_addr | input | ADDR_W | Branch or call destination |
| pc_q | output | ADDR_W | Current instruction address |
| stk_empty | output | 1 | No saved addresses |
| stk_full | output | 1 | DEPTH saved addresses |
| stk_err | output | 1 | Pulse: refused call or return |

## Verification
The bench fills the stack to exactly DEPTH entries and then calls once more. An off-by-one full flag would either refuse a legal call or overwrite the oldest entry, and the unwind would then return wrong addresses. It unwinds all the way and returns once more on the empty stack. A design that decrements past zero would load a stale address instead of pulsing the error and holding. Strobes are also raised together to expose a wrong priority. For example, a design that lets call beat return would push when it should pop. Further cases cover the wrap of the address at the top of the space and reset arriving together with a return.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_ADV  = 3'd1,
    OP_BR   = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_ERR  = 3'd5
  } pc_op_e;
endpackage

// File: rtl/pcs_op_select.sv
module pcs_op_select
  import pcs_pkg::*;
(
  input  logic   adv_en,
  input  logic   br_req,
  input  logic   call_req,
  input  logic   ret_req,
  input  logic   stk_empty,
  input  logic   stk_full,
  output pc_op_e op,
  output logic   push,
  output logic   pop,
  output logic   refuse
);
  // Fixed priority: return, call, branch, step, hold.
  always_comb begin
    if (ret_req)       op = stk_empty ? OP_ERR : OP_RET;
    else if (call_req) op = stk_full  ? OP_ERR : OP_CALL;
    else if (br_req)   op = OP_BR;
    else if (adv_en)   op = OP_ADV;
    else               op = OP_HOLD;
  end

  assign push   = (op == OP_CALL);
  assign pop    = (op == OP_RET);
  assign refuse = (op == OP_ERR);
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] top_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [PTR_W-1:0]  wr_idx;
  logic [PTR_W-1:0]  top_idx;

  assign wr_idx  = PTR_W'(cnt);
  assign top_idx = PTR_W'(cnt - CNT_W'(1));

  // Storage has no reset so it maps onto plain RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (push) cnt <= cnt + CNT_W'(1);
    else if (pop)  cnt <= cnt - CNT_W'(1);
  end

  assign top_data = mem[top_idx];
  assign empty    = (cnt == '0);
  assign full     = (cnt == CNT_MAX);

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R9
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_MAX);
  // R5
  push_grow_chk: assert property (@(posedge clk) disable iff (rst) push |=> !empty);
endmodule

// File: rtl/pc_callstack.sv
module pc_callstack
  import pcs_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DEPTH       = 8,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic              br_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [ADDR_W-1:0] pc_q,
  output logic              stk_empty,
  output logic              stk_full,
  output logic              stk_err
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  pc_op_e            op;
  logic              push, pop, refuse;
  logic [ADDR_W-1:0] top_data;
  logic [ADDR_W-1:0] next_seq;
  logic [ADDR_W-1:0] pc_d;

  assign next_seq = pc_q + STEP;

  pcs_op_select u_sel (
    .adv_en    (adv_en),
    .br_req    (br_req),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .stk_empty (stk_empty),
    .stk_full  (stk_full),
    .op        (op),
    .push      (push),
    .pop       (pop),
    .refuse    (refuse)
  );

  pcs_ret_stack #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (next_seq),
    .top_data  (top_data),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_comb begin
    unique case (op)
      OP_ADV:         pc_d = next_seq;
      OP_BR, OP_CALL: pc_d = tgt_addr;
      OP_RET:         pc_d = top_data;
      default:        pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_VEC;
      stk_err <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      stk_err <= refuse;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (pc_q == RESET_VEC && stk_empty && !stk_err));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !br_req && !call_req && !ret_req) |=> pc_q == $past(pc_q) + STEP);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv_en && !br_req && !call_req && !ret_req) |=> $stable(pc_q));
  // R5
  call_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (call_req && !ret_req && !stk_full) |=> pc_q == $past(tgt_addr));
  // R9
  empty_ret_err_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_req && stk_empty) |=> (stk_err && $stable(pc_q) && stk_empty));
  // R8
  full_call_err_chk: assert property (@(posedge clk) disable iff (rst)
    (call_req && !ret_req && stk_full) |=> (stk_err && $stable(pc_q) && stk_full));
endmodule

// File: tb/pc_callstack_tb.sv
module pc_callstack_tb;
  typedef struct packed {
    logic        rst, adv, br, call, ret;
    logic [31:0] tgt;
    logic [31:0] pc;
    logic        e, f, err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    1'b1,1'b0,1'b0, 8'd1},  // R1
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,    32'h4,    1'b1,1'b0,1'b0, 8'd2},  // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,    32'h8,    1'b1,1'b0,1'b0, 8'd2},  // R2
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h77,   32'h8,    1'b1,1'b0,1'b0, 8'd3},  // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 32'h100,  32'h100,  1'b1,1'b0,1'b0, 8'd4},  // R4
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h2000, 32'h2000, 1'b0,1'b0,1'b0, 8'd5},  // R5 push 0x104
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,    32'h2004, 1'b0,1'b0,1'b0, 8'd2},  // R2
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 32'h3000, 32'h3000, 1'b0,1'b0,1'b0, 8'd7},  // R7 call over branch, push 0x2008
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 32'h5000, 32'h2008, 1'b0,1'b0,1'b0, 8'd7},  // R7 return first
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0,    32'h104,  1'b1,1'b0,1'b0, 8'd6},  // R6
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 32'h0,    32'h104,  1'b1,1'b0,1'b1, 8'd9},  // R9
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,    32'h108,  1'b1,1'b0,1'b0, 8'd10}, // R10
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 32'h900,  32'h0,    1'b1,1'b0,1'b0, 8'd1}   // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0, br_req = 1'b0, call_req = 1'b0, ret_req = 1'b0;
  logic [31:0] tgt_addr = '0;
  logic [31:0] pc_q;
  logic        stk_empty, stk_full, stk_err;

  int total = 0;
  int bad   = 0;
  logic [31:0] saved [8];
  logic [31:0] cur;

  always #4 clk = ~clk;

  pc_callstack u_dut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .br_req(br_req), .call_req(call_req),
    .ret_req(ret_req), .tgt_addr(tgt_addr), .pc_q(pc_q), .stk_empty(stk_empty),
    .stk_full(stk_full), .stk_err(stk_err)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic b, input logic c,
                      input logic t, input logic [31:0] tg);
    @(negedge clk);
    rst = r; adv_en = a; br_req = b; call_req = c; ret_req = t; tgt_addr = tg;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("row%0d R%0d", i, v.req);
      step(v.rst, v.adv, v.br, v.call, v.ret, v.tgt);
      check({tag, " pc"},    pc_q,             v.pc);
      check({tag, " empty"}, {31'b0, stk_empty}, {31'b0, v.e});
      check({tag, " full"},  {31'b0, stk_full},  {31'b0, v.f});
      check({tag, " err"},   {31'b0, stk_err},   {31'b0, v.err});
    end

    // R8: fill to exactly eight entries
    step(1, 0, 0, 0, 0, 0);
    cur = 32'h0;
    for (int k = 0; k < 8; k++) begin
      check("R8 not full before push", {31'b0, stk_full}, 32'h0);
      saved[k] = cur + 32'h4;
      cur = 32'h1000 * (k + 1);
      step(0, 1, 0, 1, 0, cur);
      check("R5 call target", pc_q, cur);
    end
    check("R8 full at depth", {31'b0, stk_full}, 32'h1);
    step(0, 1, 0, 1, 0, 32'h9000);
    check("R8 refused call pc", pc_q, cur);
    check("R8 refused call err", {31'b0, stk_err}, 32'h1);
    check("R8 still full", {31'b0, stk_full}, 32'h1);
    step(0, 0, 0, 0, 0, 0);
    check("R10 err one cycle", {31'b0, stk_err}, 32'h0);
    // R6: unwind in reverse order
    for (int k = 7; k >= 0; k--) begin
      step(0, 1, 1, 0, 1, 32'hDEAD0000);
      check($sformatf("R6 pop %0d", k), pc_q, saved[k]);
      check("R10 no err on pop", {31'b0, stk_err}, 32'h0);
    end
    check("R6 empty after unwind", {31'b0, stk_empty}, 32'h1);
    step(0, 0, 0, 0, 1, 0);
    check("R9 empty ret pc", pc_q, saved[0]);
    check("R9 empty ret err", {31'b0, stk_err}, 32'h1);
    check("R9 still empty", {31'b0, stk_empty}, 32'h1);

    // R2: wrap at top of address space
    step(0, 0, 1, 0, 0, 32'hFFFF_FFFC);
    check("R4 branch high", pc_q, 32'hFFFF_FFFC);
    step(0, 1, 0, 0, 0, 0);
    check("R2 wrap", pc_q, 32'h0);

    // R1: reset beats a pending return
    step(0, 0, 0, 1, 0, 32'h40);
    step(1, 1, 0, 0, 1, 0);
    check("R1 reset over ret pc", pc_q, 32'h0);
    check("R1 reset empties", {31'b0, stk_empty}, 32'h1);
    step(0, 0, 0, 0, 1, 0);
    check("R1 stack really empty", {31'b0, stk_err}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule